// File: doc/BRIEF.md
# Dithered Pulse-Density NCO DAC

This block turns a 12-bit code into a single-bit pulse-density stream. A 32-bit phase register has a step value added to it on every clock, and the carry out of that addition is the output bit. A low-pass filter outside the chip averages the bit into a voltage proportional to step / 2^32. A complementary output bit drives a balanced or differential filter.

The code is mapped to the step in one of three ways. The plain mapping is a left shift. The fill mapping repeats the code in the low bits. The biased mapping adds a small fixed fraction after the shift. The last two keep the mid-scale step off the pure power of two 0x8000_0000. At that value the pulse train locks to the counter rollover and the local linearity suffers. An optional pseudo-random term from a shift register can be added to the low bits of the step to spread quantisation error.

A new code takes effect only when it is strobed in. A small load sequencer first captures the code and then commits the mapped step. The phase register is never cleared by a load, so the pulse train keeps its phase across code changes.

The sequencer has three states. ST_IDLE holds after reset, with a zero step. ST_MAP holds for one cycle after a strobe, while the captured code is being mapped. ST_RUN holds while the committed step is in use. The transitions are:
- ST_IDLE to ST_MAP on a strobe.
- ST_MAP to ST_MAP on another strobe.
- ST_MAP to ST_RUN when no strobe is present.
- ST_RUN to ST_MAP on a strobe.
- ST_IDLE and ST_RUN each hold when no strobe is present.

Top module: `nco_dac_top`

## Requirements
- R1: A synchronous reset clears the phase register and the committed step to zero, drives pulse_o low and pulse_n_o high, and returns the sequencer to ST_IDLE. Until a code is strobed in, pulse_o stays low.
- R2: pulse_o carries the carry of each 32-bit phase addition. A strobe is sampled at rising edge A. The new step is used from edge A+2 on, and each pulse_o value is registered at the edge whose addition produced it. Starting from zero phase, N additions with step S therefore give floor(N*S/2^32) ones.
- R3: For mode_i = 2'b00, and also for 2'b11, the step is code << 20.
- R4: For mode_i = 2'b01, the step is ((code << 12) + code) << 8.
- R5: For mode_i = 2'b10, the step is (code << 20) + bias_i, modulo 2^32. In the fill mode, and in the biased mode with a nonzero bias_i, the mid-scale code 0x800 never produces the step 0x8000_0000.
- R6: The step changes only through a strobe on load_i. A change of code_i without a strobe has no effect on the output.
- R7: A strobe does not reset the phase register. The count of ones across a code change equals floor((n_old*S_old + n_new*S_new)/2^32).
- R8: pulse_n_o is always the inverse of pulse_o.
- R9: When dither_en_i is high, a 4-bit pseudo-random value is added to the step before the phase addition. That sum saturates at 2^32-1. Over 8192 cycles, the count of ones is at least the undithered count and at most one more.
- R10: Within each mode, and at a fixed bias, the count of ones over a fixed window does not decrease as the code increases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Code-to-step mapping select; static outside reset |
| bias_i | input | 32 | Fraction added in the biased mapping; static outside reset |
| dither_en_i | input | 1 | Adds the pseudo-random term to the step; static outside reset |
| code_i | input | 12 | Output level code |
| load_i | input | 1 | Strobe that captures code_i |
| pulse_o | output | 1 | Pulse-density output bit |
| pulse_n_o | output | 1 | Inverse of pulse_o |

## Verification
The properties assume three things about the inputs:
- mode_i, bias_i and dither_en_i change only while reset is held. The mid-scale property and the zero-step property read them together with the committed step.
- The mid-scale property applies only in the fill mode and in the biased mode with a nonzero bias.
- The zero-step property holds only while dithering is off.

The stimulus respects this. It sets the mode, bias and dither enable before each reset is released and leaves them unchanged until the next reset. It raises the strobe for exactly one cycle per code.

// File: rtl/nco_dac_pkg.sv
package nco_dac_pkg;

    // Code-to-step mapping; the encoding is the mode_i port value.
    typedef enum logic [1:0] {
        MAP_PLAIN     = 2'b00,
        MAP_FILL      = 2'b01,
        MAP_BIAS      = 2'b10,
        MAP_PLAIN_ALT = 2'b11
    } map_mode_e;

    // Load sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_MAP  = 2'b01,
        ST_RUN  = 2'b10
    } load_state_e;

endpackage

// File: rtl/nco_incr_map.sv
module nco_incr_map
    import nco_dac_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int CODE_W = 12
) (
    input  map_mode_e          mode_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic [ACC_W-1:0]   bias_i,
    output logic [ACC_W-1:0]   step_o
);
    localparam int COARSE_SH = ACC_W - CODE_W;
    localparam int FILL_SH   = ACC_W - 2 * CODE_W;

    logic [ACC_W-1:0] code_ext;
    logic [ACC_W-1:0] step_coarse;
    logic [ACC_W-1:0] step_fill;
    logic [ACC_W-1:0] step_bias;

    assign code_ext    = {{(ACC_W - CODE_W){1'b0}}, code_i};
    assign step_coarse = code_ext << COARSE_SH;
    // Code repeated once below itself, then moved up to full scale.
    assign step_fill   = ((code_ext << CODE_W) + code_ext) << FILL_SH;
    // Fixed fraction on top of the shifted code, wrapping modulo 2^ACC_W.
    assign step_bias   = step_coarse + bias_i;

    always_comb begin
        unique case (mode_i)
            MAP_FILL:      step_o = step_fill;
            MAP_BIAS:      step_o = step_bias;
            MAP_PLAIN,
            MAP_PLAIN_ALT: step_o = step_coarse;
            default:       step_o = step_coarse;
        endcase
    end

endmodule

// File: rtl/nco_dither_lfsr.sv
module nco_dither_lfsr #(
    parameter int              LFSR_W   = 16,
    parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
    parameter int              DITHER_W = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    output logic [DITHER_W-1:0] dither_o
);
    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_d;

    // Galois form: shift right, fold the taps in when a one drops out.
    always_comb begin
        lfsr_d = {1'b0, lfsr_q[LFSR_W-1:1]};
        if (lfsr_q[0]) begin
            lfsr_d = lfsr_d ^ TAPS;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    assign dither_o = lfsr_q[DITHER_W-1:0];

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W    = 32,
    parameter int DITHER_W = 4,
    parameter bit COMP_EN  = 1'b1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [ACC_W-1:0]    step_i,
    input  logic [DITHER_W-1:0] dither_i,
    input  logic                dither_en_i,
    output logic                pulse_o,
    output logic                pulse_n_o
);
    logic [ACC_W:0]   dith_ext;
    logic [ACC_W:0]   step_sum;
    logic [ACC_W-1:0] step_eff;
    logic [ACC_W:0]   phase_sum;
    logic [ACC_W-1:0] phase_q;
    logic             pulse_q;

    assign dith_ext  = dither_en_i ? {{(ACC_W + 1 - DITHER_W){1'b0}}, dither_i} : '0;
    assign step_sum  = {1'b0, step_i} + dith_ext;
    // Saturate so that dither can never wrap a near-full-scale step to a small one.
    assign step_eff  = step_sum[ACC_W] ? {ACC_W{1'b1}} : step_sum[ACC_W-1:0];
    assign phase_sum = {1'b0, phase_q} + {1'b0, step_eff};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            phase_q <= phase_sum[ACC_W-1:0];
            pulse_q <= phase_sum[ACC_W];
        end
    end

    assign pulse_o = pulse_q;

    generate
        if (COMP_EN) begin : g_comp
            logic pulse_n_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    pulse_n_q <= 1'b1;
                end else begin
                    pulse_n_q <= ~phase_sum[ACC_W];
                end
            end
            assign pulse_n_o = pulse_n_q;
        end else begin : g_no_comp
            assign pulse_n_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/nco_dac_top.sv
module nco_dac_top
    import nco_dac_pkg::*;
#(
    parameter int                ACC_W     = 32,
    parameter int                CODE_W    = 12,
    parameter int                DITHER_W  = 4,
    parameter int                LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    parameter bit                COMP_EN   = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        mode_i,
    input  logic [31:0]       bias_i,
    input  logic              dither_en_i,
    input  logic [11:0]       code_i,
    input  logic              load_i,
    output logic              pulse_o,
    output logic              pulse_n_o
);
    load_state_e       state_q;
    load_state_e       state_d;
    logic [CODE_W-1:0] code_q;
    logic [ACC_W-1:0]  incr_q;
    logic [ACC_W-1:0]  mapped_step;
    logic [DITHER_W-1:0] dither;
    logic              capture_code;
    logic              commit_step;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_i) state_d = ST_MAP;
            ST_MAP:  state_d = load_i ? ST_MAP : ST_RUN;
            ST_RUN:  if (load_i) state_d = ST_MAP;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // State outputs.
    always_comb begin
        capture_code = load_i;
        commit_step  = (state_q == ST_MAP);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            code_q <= '0;
            incr_q <= '0;
        end else begin
            if (capture_code) code_q <= code_i[CODE_W-1:0];
            if (commit_step)  incr_q <= mapped_step;
        end
    end

    nco_incr_map #(
        .ACC_W  (ACC_W),
        .CODE_W (CODE_W)
    ) u_map (
        .mode_i (map_mode_e'(mode_i)),
        .code_i (code_q),
        .bias_i (bias_i[ACC_W-1:0]),
        .step_o (mapped_step)
    );

    nco_dither_lfsr #(
        .LFSR_W   (LFSR_W),
        .TAPS     (LFSR_TAPS),
        .SEED     (LFSR_SEED),
        .DITHER_W (DITHER_W)
    ) u_lfsr (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .dither_o (dither)
    );

    nco_phase_acc #(
        .ACC_W    (ACC_W),
        .DITHER_W (DITHER_W),
        .COMP_EN  (COMP_EN)
    ) u_acc (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .step_i      (incr_q),
        .dither_i    (dither),
        .dither_en_i (dither_en_i),
        .pulse_o     (pulse_o),
        .pulse_n_o   (pulse_n_o)
    );

endmodule

// File: rtl/nco_dac_chk.sv
module nco_dac_chk
    import nco_dac_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int CODE_W  = 12,
    parameter bit COMP_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic [31:0]       bias,
    input  logic              dither_en,
    input  logic [CODE_W-1:0] code_q,
    input  logic [ACC_W-1:0]  incr_q,
    input  load_state_e       state,
    input  logic              pulse,
    input  logic              pulse_n
);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
    localparam logic [ACC_W-1:0]  POW2_MID = ACC_W'(1) << (ACC_W - 1);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (!pulse && incr_q == '0 && state == ST_IDLE)); // R1

    AST_IDLE_ZERO_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (incr_q == '0)); // R1

    AST_ZERO_STEP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (incr_q == '0 && !dither_en) |=> !pulse); // R2

    AST_MID_NOT_POW2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && code_q == MID_CODE &&
         (mode == 2'b01 || (mode == 2'b10 && bias != '0))) |-> (incr_q != POW2_MID)); // R5

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN || state == ST_IDLE) |=> $stable(incr_q)); // R6

    generate
        if (COMP_EN) begin : g_comp_chk
            AST_COMP_PAIR: assert property (@(posedge clk) disable iff (rst)
                pulse_n == !pulse); // R8
        end
    endgenerate

endmodule

bind nco_dac_top nco_dac_chk #(
    .ACC_W   (ACC_W),
    .CODE_W  (CODE_W),
    .COMP_EN (COMP_EN)
) u_chk (
    .clk       (clk_i),
    .rst       (rst_i),
    .mode      (mode_i),
    .bias      (bias_i),
    .dither_en (dither_en_i),
    .code_q    (code_q),
    .incr_q    (incr_q),
    .state     (state_q),
    .pulse     (pulse_o),
    .pulse_n   (pulse_n_o)
);

// File: tb/nco_dac_top_test.sv
`timescale 1ns/1ps
module nco_dac_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic [31:0] bias = 32'h0;
    logic        dither_en = 1'b0;
    logic [11:0] code = 12'h0;
    logic        load = 1'b0;
    logic        pulse;
    logic        pulse_n;

    int  checks = 0;
    int  errs   = 0;
    bit  done   = 1'b0;

    localparam int WIN = 8192;

    // {mode[61:60], code[59:48], bias[47:16], expected ones over WIN[15:0]}
    localparam logic [61:0] VECS [14] = '{
        {2'b00, 12'h000, 32'h0000_0000, 16'd0},
        {2'b00, 12'h001, 32'h0000_0000, 16'd2},
        {2'b00, 12'h400, 32'h0000_0000, 16'd2048},
        {2'b00, 12'h800, 32'h0000_0000, 16'd4096},
        {2'b00, 12'hFFF, 32'h0000_0000, 16'd8190},
        {2'b01, 12'h001, 32'h0000_0000, 16'd2},
        {2'b01, 12'h7FF, 32'h0000_0000, 16'd4094},
        {2'b01, 12'h800, 32'h0000_0000, 16'd4097},
        {2'b01, 12'hFFF, 32'h0000_0000, 16'd8191},
        {2'b10, 12'h800, 32'h0000_0143, 16'd4096},
        {2'b10, 12'hFFF, 32'h0000_0143, 16'd8190},
        {2'b10, 12'h000, 32'h0008_0000, 16'd1},
        {2'b10, 12'h800, 32'h0008_0000, 16'd4097},
        {2'b11, 12'h400, 32'h0000_0000, 16'd2048}
    };

    nco_dac_top uut (
        .clk_i       (clk),
        .rst_i       (rst),
        .mode_i      (mode),
        .bias_i      (bias),
        .dither_en_i (dither_en),
        .code_i      (code),
        .load_i      (load),
        .pulse_o     (pulse),
        .pulse_n_o   (pulse_n)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        load = 1'b0;
        repeat (2) @(negedge clk);
        check(pulse == 1'b0 && pulse_n == 1'b1, "R1 outputs during reset",
              longint'({pulse, pulse_n}), 64'd1);
        rst = 1'b0;
    endtask

    // Returns so that the next negedge samples the first addition with the new step.
    task automatic load_code(input logic [11:0] c);
        @(negedge clk);
        load = 1'b1;
        code = c;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
    endtask

    task automatic count_window(input int n, output longint ones, output int comp_bad);
        ones = 0;
        comp_bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ones += longint'(pulse);
            if (pulse_n !== ~pulse) comp_bad++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        longint ones;
        longint prev;
        int     bad;
        logic [1:0]  prev_mode;
        logic [31:0] prev_bias;
        longint exp_l;

        // R1: reset state, then no pulses without a strobe.
        do_reset();
        count_window(200, ones, bad);
        check(ones == 0, "R1 silent after reset without load", ones, 0);

        // Table walk: R2 exact counts per mode, R8 complement, R10 monotonic order.
        prev = 0;
        prev_mode = 2'bxx;
        prev_bias = 32'hx;
        for (int v = 0; v < 14; v++) begin
            mode = VECS[v][61:60];
            bias = VECS[v][47:16];
            do_reset();
            load_code(VECS[v][59:48]);
            count_window(WIN, ones, bad);
            case (mode)
                2'b01:   check(ones == longint'(VECS[v][15:0]), "R2 R4 fill mode count", ones, longint'(VECS[v][15:0]));
                2'b10:   check(ones == longint'(VECS[v][15:0]), "R2 R5 biased mode count", ones, longint'(VECS[v][15:0]));
                default: check(ones == longint'(VECS[v][15:0]), "R2 R3 plain mode count", ones, longint'(VECS[v][15:0]));
            endcase
            check(bad == 0, "R8 complement mismatches", bad, 0);
            if (mode === prev_mode && bias === prev_bias) begin
                check(ones >= prev, "R10 count not monotonic", ones, prev);
            end
            prev = ones;
            prev_mode = mode;
            prev_bias = bias;
        end

        // R6: code_i change without a strobe is ignored.
        mode = 2'b00;
        bias = 32'h0;
        do_reset();
        load_code(12'h400);
        @(negedge clk);
        code = 12'hFFF;
        count_window(4096, ones, bad);
        check(ones == 1024, "R6 unstrobed code ignored", ones, 1024);

        // R7: phase carried across a load (1002 old additions, 2998 new).
        do_reset();
        load_code(12'h300);
        ones = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            ones += longint'(pulse);
        end
        load = 1'b1;
        code = 12'hA00;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            load = 1'b0;
            ones += longint'(pulse);
        end
        exp_l = (1002 * 64'h3000_0000 + 2998 * 64'hA000_0000) >> 32;
        check(ones == exp_l, "R7 phase continuity across load", ones, exp_l);

        // R1: reset in the middle of a run clears the step.
        load_code(12'h800);
        count_window(50, ones, bad);
        do_reset();
        count_window(100, ones, bad);
        check(ones == 0, "R1 mid-run reset clears step", ones, 0);

        // R9: dither bounded count.
        dither_en = 1'b1;
        mode = 2'b00;
        do_reset();
        load_code(12'h400);
        count_window(WIN, ones, bad);
        check(ones >= 2048 && ones <= 2049, "R9 dithered count bounds", ones, 2048);

        // R9: saturation near full scale keeps nearly every cycle high.
        mode = 2'b10;
        bias = 32'h000F_FFFF;
        do_reset();
        load_code(12'hFFF);
        count_window(WIN, ones, bad);
        check(ones == 8191, "R9 saturated dithered step", ones, 8191);
        dither_en = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule